// File: doc/BRIEF.md
# Filtered Quadrature Input Decoder

This block takes the two raw phase signals of an incremental encoder and turns them into count pulses with a direction bit, ready for a separate position counter. Each input is first brought into the clock domain, then checked by a glitch filter that samples on ticks from a programmable divider. The filter accepts a new level only after the level has been seen on two sample ticks in a row. Raising the divider value therefore widens the noise window the filter rejects.

The filtered phases are decoded at one of four resolutions. The three quadrature modes count on every phase edge, on edges of phase A only, or on rising edges of phase A only. The fourth mode treats A as a count clock and B as a direction level. In the quadrature modes, a filtered step where both phases move at once means the filter could not separate them. Such a step produces no count and sets a sticky error bit, which stays set until the control input clears it.

Top module: `qdec_filtered`

## Requirements
- R1: After reset, `cnt_en_o`, `cnt_up_o` and `err_o` are all low.
- R2: The sample tick repeats every `prescale_i`+1 clock cycles, and a value of 0 samples on every clock. With `prescale_i`=7, a 7-cycle pulse is rejected and a 40-cycle pulse is accepted. With `prescale_i`=0, the same 7-cycle pulse is accepted.
- R3: A filtered phase changes only on a sample tick, and only to a level seen on two consecutive ticks. A one-cycle pulse on A with `prescale_i`=0 yields no count.
- R4: `mode_i`=2 (x4): every accepted edge of A or of B gives one count.
- R5: `mode_i`=1 (x2): every accepted edge of A gives one count. Edges of B give none.
- R6: `mode_i`=0 (x1): only accepted rising edges of A give a count.
- R7: In the quadrature modes, `cnt_up_o`=1 when A leads B, that is for the sequence AB = 00,10,11,01. The reverse sequence gives `cnt_up_o`=0.
- R8: `mode_i`=3 (clock/direction): each accepted rising edge of A gives one count, and `cnt_up_o` equals the filtered level of B. Edges of B alone give no count.
- R9: In modes 0 to 2, an accepted step in which A and B change together produces no count and sets `err_o`. In mode 3, the same step does not set `err_o`.
- R10: `err_o` stays set until a cycle with `err_clr_i` high clears it. If a new error and the clear fall in the same cycle, the error wins.
- R11: Each count is a single-cycle pulse on `cnt_en_o`, two clock cycles after the sample tick that accepted the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale_i | input | PS_W (8) | Sample divider; tick period is value+1 clocks |
| mode_i | input | 2 | 0 x1, 1 x2, 2 x4, 3 clock/direction |
| enc_a_i | input | 1 | Raw phase A |
| enc_b_i | input | 1 | Raw phase B |
| err_clr_i | input | 1 | Clears the sticky error bit |
| cnt_en_o | output | 1 | One-cycle count pulse |
| cnt_up_o | output | 1 | Direction of the count, 1 = up; valid with `cnt_en_o` |
| err_o | output | 1 | Sticky illegal-step flag |

## Verification
A divider that drifts from its programmed period shows up as a wrong pass/reject outcome for a fixed-width pulse, within one pulse. A filter history that lets a single sample through turns a one-cycle glitch into a pair of opposite counts within a few cycles. A decoder keeping a stale previous phase miscounts or reverses direction on the very next step. A lost or never-set error state is visible on `err_o` within two cycles after the offending tick.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   typedef enum logic [1:0] {
      QM_X1  = 2'd0,
      QM_X2  = 2'd1,
      QM_X4  = 2'd2,
      QM_DIR = 2'd3
   } qmode_e;
endpackage

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
   parameter int PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PS_W-1:0] div_i,
   output logic            tick_o
);
   initial begin
      assert (PS_W >= 1) else $error("qdec_prescaler: PS_W must be at least 1");
   end

   logic [PS_W-1:0] cnt_q;

   assign tick_o = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= div_i;
      else             cnt_q <= cnt_q - 1'b1;
   end

   // R2: a nonzero divider never yields back-to-back ticks
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/qdec_sync_filter.sv
module qdec_sync_filter #(
   parameter int SYNC_STAGES  = 2,
   parameter int STABLE_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic raw_i,
   output logic filt_o
);
   initial begin
      assert (SYNC_STAGES >= 0) else $error("qdec_sync_filter: SYNC_STAGES negative");
      assert (STABLE_TICKS >= 2) else $error("qdec_sync_filter: STABLE_TICKS below 2");
   end

   logic s_in;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign s_in = raw_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else begin
               sync_q[0] <= raw_i;
               for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign s_in = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [STABLE_TICKS-1:0] hist_q;
   logic [STABLE_TICKS-1:0] hist_nxt;
   logic                    filt_q;

   assign hist_nxt = {hist_q[STABLE_TICKS-2:0], s_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         filt_q <= 1'b0;
      end else if (tick_i) begin
         hist_q <= hist_nxt;
         if (&hist_nxt)       filt_q <= 1'b1;
         else if (~|hist_nxt) filt_q <= 1'b0;
      end
   end

   assign filt_o = filt_q;

   // R3: the accepted level moves only on a sample tick
   assert_filt_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(filt_q));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
   import qdec_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  qmode_e mode_i,
   input  logic   fa_i,
   input  logic   fb_i,
   input  logic   err_clr_i,
   output logic   cnt_en_o,
   output logic   cnt_up_o,
   output logic   err_o
);
   logic pa_q, pb_q;
   logic a_chg, b_chg;
   logic en_c, up_c, bad_c;
   logic en_q, up_q, err_q;

   assign a_chg = fa_i ^ pa_q;
   assign b_chg = fb_i ^ pb_q;

   always_comb begin
      en_c  = 1'b0;
      up_c  = 1'b0;
      bad_c = 1'b0;
      case (mode_i)
         QM_X4: begin
            if (a_chg && b_chg) bad_c = 1'b1;
            else if (a_chg) begin en_c = 1'b1; up_c = fa_i ^ fb_i;    end
            else if (b_chg) begin en_c = 1'b1; up_c = ~(fa_i ^ fb_i); end
         end
         QM_X2: begin
            if (a_chg && b_chg) bad_c = 1'b1;
            else if (a_chg) begin en_c = 1'b1; up_c = fa_i ^ fb_i; end
         end
         QM_X1: begin
            if (a_chg && b_chg) bad_c = 1'b1;
            else if (a_chg && fa_i) begin en_c = 1'b1; up_c = ~fb_i; end
         end
         default: begin
            if (a_chg && fa_i) begin en_c = 1'b1; up_c = fb_i; end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_q  <= 1'b0;
         pb_q  <= 1'b0;
         en_q  <= 1'b0;
         up_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         pa_q <= fa_i;
         pb_q <= fb_i;
         en_q <= en_c;
         up_q <= up_c;
         if (bad_c)          err_q <= 1'b1;
         else if (err_clr_i) err_q <= 1'b0;
      end
   end

   assign cnt_en_o = en_q;
   assign cnt_up_o = up_q;
   assign err_o    = err_q;

   // R10: the flag holds while no clear is requested
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr_i) |=> err_q);

   // R10: a fresh illegal step beats a simultaneous clear
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_chg && b_chg && mode_i != QM_DIR && err_clr_i) |=> err_q);

   // R9: clock/direction mode never raises the flag
   assert_dir_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(mode_i) != QM_DIR);
endmodule

// File: rtl/qdec_filtered.sv
module qdec_filtered
   import qdec_pkg::*;
#(
   parameter int PS_W         = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int STABLE_TICKS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PS_W-1:0] prescale_i,
   input  logic [1:0]      mode_i,
   input  logic            enc_a_i,
   input  logic            enc_b_i,
   input  logic            err_clr_i,
   output logic            cnt_en_o,
   output logic            cnt_up_o,
   output logic            err_o
);
   localparam int N_CH = 2;

   logic            tick;
   logic [N_CH-1:0] raw_vec;
   logic [N_CH-1:0] filt_vec;

   assign raw_vec = {enc_b_i, enc_a_i};

   qdec_prescaler #(.PS_W(PS_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .div_i (prescale_i),
      .tick_o(tick)
   );

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
         qdec_sync_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .STABLE_TICKS(STABLE_TICKS)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick),
            .raw_i (raw_vec[ch]),
            .filt_o(filt_vec[ch])
         );
      end
   endgenerate

   qdec_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (qmode_e'(mode_i)),
      .fa_i     (filt_vec[0]),
      .fb_i     (filt_vec[1]),
      .err_clr_i(err_clr_i),
      .cnt_en_o (cnt_en_o),
      .cnt_up_o (cnt_up_o),
      .err_o    (err_o)
   );

   // R11: a count pulse follows the accepting tick by two cycles
   assert_cnt_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en_o |-> $past(tick, 2));

   // R11: count pulses from one accepted edge last a single cycle in slow sampling
   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en_o && prescale_i != '0 && $stable(prescale_i)) |=> !cnt_en_o);
endmodule

// File: tb/tb_qdec_filtered.sv
`timescale 1ns/1ps
module tb_qdec_filtered;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] prescale_i = 8'd0;
   logic [1:0] mode_i = 2'd2;
   logic       enc_a_i = 1'b0;
   logic       enc_b_i = 1'b0;
   logic       err_clr_i = 1'b0;
   logic       cnt_en_o, cnt_up_o, err_o;

   int checks = 0;
   int fails  = 0;
   int n_up = 0, n_dn = 0;
   bit err_seen = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   qdec_filtered dut (
      .clk(clk), .rst_n(rst_n), .prescale_i(prescale_i), .mode_i(mode_i),
      .enc_a_i(enc_a_i), .enc_b_i(enc_b_i), .err_clr_i(err_clr_i),
      .cnt_en_o(cnt_en_o), .cnt_up_o(cnt_up_o), .err_o(err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cnt_en_o) begin
            if (cnt_up_o) n_up++; else n_dn++;
         end
         if (err_o) err_seen = 1'b1;
      end
   endtask

   task automatic step(input logic a, input logic b, input int hold);
      @(posedge clk); #2;
      enc_a_i = a;
      enc_b_i = b;
      run(hold);
   endtask

   task automatic zero_counts();
      n_up = 0; n_dn = 0; err_seen = 1'b0;
   endtask

   task automatic fwd_cycle(input int hold);
      step(1, 0, hold); step(1, 1, hold); step(0, 1, hold); step(0, 0, hold);
   endtask

   task automatic rev_cycle(input int hold);
      step(0, 1, hold); step(1, 1, hold); step(1, 0, hold); step(0, 0, hold);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 cnt_en after reset", cnt_en_o, 0);
      chk("R1 cnt_up after reset", cnt_up_o, 0);
      chk("R1 err after reset", err_o, 0);
   endtask

   task automatic t_x4();
      mode_i = 2'd2; prescale_i = 8'd0; zero_counts();
      fwd_cycle(8); fwd_cycle(8); run(30);
      chk("R4 x4 forward up", n_up, 8);
      chk("R7 x4 forward down", n_dn, 0);
      zero_counts(); rev_cycle(8); run(30);
      chk("R7 x4 reverse down", n_dn, 4);
      chk("R4 x4 reverse up", n_up, 0);
   endtask

   task automatic t_x2();
      mode_i = 2'd1; zero_counts();
      fwd_cycle(8); run(30);
      chk("R5 x2 forward up", n_up, 2);
      zero_counts(); rev_cycle(8); run(30);
      chk("R5 x2 reverse down", n_dn, 2);
      chk("R7 x2 reverse up", n_up, 0);
   endtask

   task automatic t_x1();
      mode_i = 2'd0; zero_counts();
      fwd_cycle(8); run(30);
      chk("R6 x1 forward up", n_up, 1);
      chk("R6 x1 forward down", n_dn, 0);
      zero_counts(); rev_cycle(8); run(30);
      chk("R6 x1 reverse down", n_dn, 1);
      chk("R7 x1 reverse up", n_up, 0);
   endtask

   task automatic t_dir();
      mode_i = 2'd3; zero_counts();
      step(0, 1, 10);
      for (int k = 0; k < 3; k++) begin step(1, 1, 8); step(0, 1, 8); end
      step(0, 0, 10);
      for (int k = 0; k < 2; k++) begin step(1, 0, 8); step(0, 0, 8); end
      run(30);
      chk("R8 dir up count", n_up, 3);
      chk("R8 dir down count", n_dn, 2);
      zero_counts();
      step(1, 1, 20); run(20);
      chk("R9 dir joint step no err", err_o, 0);
      chk("R8 dir joint step counts up", n_up, 1);
      step(0, 0, 30);
   endtask

   task automatic t_filter();
      mode_i = 2'd2; prescale_i = 8'd0; zero_counts();
      step(1, 0, 1); step(0, 0, 40);
      chk("R3 one-cycle glitch rejected", n_up + n_dn, 0);
      prescale_i = 8'd7; zero_counts(); run(20);
      step(1, 0, 7); step(0, 0, 80);
      chk("R2 7-cycle pulse rejected at div 7", n_up + n_dn, 0);
      zero_counts();
      step(1, 0, 40); step(0, 0, 80);
      chk("R2 40-cycle pulse up at div 7", n_up, 1);
      chk("R2 40-cycle pulse down at div 7", n_dn, 1);
      prescale_i = 8'd0; zero_counts(); run(20);
      step(1, 0, 7); step(0, 0, 40);
      chk("R2 7-cycle pulse accepted at div 0", n_up + n_dn, 2);
   endtask

   task automatic t_error();
      mode_i = 2'd2; prescale_i = 8'd0; zero_counts();
      step(1, 1, 20);
      chk("R9 joint step sets err", err_o, 1);
      chk("R9 joint step gives no count", n_up + n_dn, 0);
      run(40);
      chk("R10 err holds without clear", err_o, 1);
      @(posedge clk); #2; err_clr_i = 1'b1;
      @(posedge clk); #2; err_clr_i = 1'b0;
      run(2);
      chk("R10 clear drops err", err_o, 0);
      zero_counts();
      @(posedge clk); #2; err_clr_i = 1'b1;
      step(0, 0, 30);
      chk("R10 set wins over held clear", err_seen, 1);
      chk("R10 held clear ends low", err_o, 0);
      @(posedge clk); #2; err_clr_i = 1'b0;
      zero_counts();
      mode_i = 2'd0; step(1, 1, 20);
      chk("R9 x1 joint step sets err", err_o, 1);
      chk("R9 x1 joint step no count", n_up + n_dn, 0);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_x4();
      t_x2();
      t_x1();
      t_dir();
      t_filter();
      t_error();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
         $finish;
      end
   end
endmodule